// File: doc/BRIEF.md
# Glitch-Free Dual-Source Clock Reprogrammer

This block moves a core clock onto a new source and divider without ever touching the settings that currently drive it. The clock-control register holds two source slots, each with a source-select field and a divider field. A single bit in the clock-select register decides which slot is live. On a start request the block programs the slot that is not live, then flips the select bit so that slot takes over. The slot that had been live becomes the idle slot for the next change.

The same select register also carries a bus clock divider. The block orders that write against the source flip. A larger divider is written before the flip and a smaller one after it, so the bus never runs faster than its new or old setting allows. An unchanged divider is not written at all.

The block holds its own images of both registers and emits each write as a read-modify-write of that image, one write per cycle. The clocks themselves are generated elsewhere.

Top module: `clkrp_top`

## Requirements
- R1: After reset the block is idle, with `busy_o`, `done_o` and `wr_valid_o` low. The register images equal the parameters `CTRL_RST` and `SEL_RST`, and the first read-modify-write is based on those values.
- R2: `start_i` is taken only in state IDLE, and it latches the three targets. A start pulse while `busy_o` is high has no effect on the write sequence in progress.
- R3: Select bit 0 = 0 makes the high slot live (source at control bits 14:12, divider at 11:8). Select bit 0 = 1 makes the low slot live (source at 6:4, divider at 3:0). The idle slot is written in two writes to the control register (`wr_addr_o` = 0): the source field first (state SLOT_SRC), then the divider field (state SLOT_DIV).
- R4: After the two slot writes, one write to the select register (`wr_addr_o` = 1, state FLIP) inverts bit 0 and changes no other bit.
- R5: If the target bus divider is greater than select bits 2:1, a select write carrying the new value in bits 2:1 (state BUS_UP) comes before the source write.
- R6: If the target bus divider is less than select bits 2:1, the bus-divider write (state BUS_DOWN) comes directly after the flip.
- R7: If the target bus divider equals select bits 2:1, no bus-divider write is issued, and the sequence is exactly three writes.
- R8: Every write preserves all bits of its register outside the field it changes. A select write carries zeros above bit `SEL_W`-1.
- R9: Writes are issued on consecutive cycles, one per cycle, with `wr_valid_o` high for each. `done_o` is high for exactly the one cycle after the last write (state DONE), and the block is idle on the following cycle.
- R10: No control-register write alters either field of the live slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a clock change; taken while idle |
| src_sel_i | input | SRC_W | Target source select |
| core_div_i | input | CDIV_W | Target core divider |
| bus_div_i | input | BDIV_W | Target bus divider |
| busy_o | output | 1 | A change is in progress |
| done_o | output | 1 | One-cycle pulse after the last write |
| wr_valid_o | output | 1 | A register write is presented this cycle |
| wr_addr_o | output | 1 | 0 = clock-control register, 1 = clock-select register |
| wr_data_o | output | CTRL_W | Full new register value; select writes are zero-extended |

## Verification
The bench builds the block with non-zero reset images: `CTRL_RST` = 16'h7C96 and `SEL_RST` = 8'hE2. With these values the live high slot, the untouched bit 7 and the upper select bits all hold ones that a careless mask would clear. The bus divider starts at 1, so both a rise and a fall can be reached from reset. A chain of changes then alternates the live slot, so both slot layouts get programmed and the fields of the live slot are checked for stability in both positions.

// File: rtl/clkrp_pkg.sv
package clkrp_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUS_UP,
        ST_SLOT_SRC,
        ST_SLOT_DIV,
        ST_FLIP,
        ST_BUS_DOWN,
        ST_DONE
    } clkrp_state_e;

    // Kind of register write requested from the merge logic
    typedef enum logic [2:0] {
        OP_NONE,
        OP_BUS,
        OP_SRC,
        OP_DIV,
        OP_FLIP
    } clkrp_op_e;

    // Select register: bit that picks the live slot, and base of the bus divider
    localparam int SEL_BIT = 0;
    localparam int BUS_LSB = 1;

    // Write targets
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_SEL  = 1'b1;

endpackage

// File: rtl/clkrp_seq.sv
module clkrp_seq
    import clkrp_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      start_i,
    input  logic      up_req_i,
    input  logic      down_req_i,
    output logic      load_o,
    output clkrp_op_e op_o,
    output logic      wr_valid_o,
    output logic      busy_o,
    output logic      done_o
);

    clkrp_state_e state_q, state_d;
    logic         up_q, down_q;

    // State register and latched bus-order decision
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            up_q    <= 1'b0;
            down_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_o) begin
                up_q   <= up_req_i;
                down_q <= down_req_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = up_req_i ? ST_BUS_UP : ST_SLOT_SRC;
                end
            end
            ST_BUS_UP:   state_d = ST_SLOT_SRC;
            ST_SLOT_SRC: state_d = ST_SLOT_DIV;
            ST_SLOT_DIV: state_d = ST_FLIP;
            ST_FLIP:     state_d = down_q ? ST_BUS_DOWN : ST_DONE;
            ST_BUS_DOWN: state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        load_o     = 1'b0;
        op_o       = OP_NONE;
        wr_valid_o = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i;
            end
            ST_BUS_UP: begin
                op_o       = OP_BUS;
                wr_valid_o = 1'b1;
            end
            ST_SLOT_SRC: begin
                op_o       = OP_SRC;
                wr_valid_o = 1'b1;
            end
            ST_SLOT_DIV: begin
                op_o       = OP_DIV;
                wr_valid_o = 1'b1;
            end
            ST_FLIP: begin
                op_o       = OP_FLIP;
                wr_valid_o = 1'b1;
            end
            ST_BUS_DOWN: begin
                op_o       = OP_BUS;
                wr_valid_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clkrp_image.sv
module clkrp_image #(
    parameter int              CTRL_W   = 16,
    parameter int              SEL_W    = 8,
    parameter int              SRC_W    = 3,
    parameter int              CDIV_W   = 4,
    parameter int              BDIV_W   = 2,
    parameter logic [CTRL_W-1:0] CTRL_RST = '0,
    parameter logic [SEL_W-1:0]  SEL_RST  = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [SRC_W-1:0]  src_sel_i,
    input  logic [CDIV_W-1:0] core_div_i,
    input  logic [BDIV_W-1:0] bus_div_i,
    input  logic              wr_valid_i,
    input  logic              wr_addr_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] ctrl_q_o,
    output logic [SEL_W-1:0]  sel_q_o,
    output logic [SRC_W-1:0]  tgt_src_o,
    output logic [CDIV_W-1:0] tgt_cdiv_o,
    output logic [BDIV_W-1:0] tgt_bdiv_o
);
    import clkrp_pkg::*;

    // Register images follow the writes that leave the block
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q_o <= CTRL_RST;
            sel_q_o  <= SEL_RST;
        end else if (wr_valid_i) begin
            if (wr_addr_i == ADDR_CTRL) begin
                ctrl_q_o <= wr_data_i;
            end else begin
                sel_q_o <= wr_data_i[SEL_W-1:0];
            end
        end
    end

    // Targets captured when a change is accepted
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tgt_src_o  <= '0;
            tgt_cdiv_o <= '0;
            tgt_bdiv_o <= '0;
        end else if (load_i) begin
            tgt_src_o  <= src_sel_i;
            tgt_cdiv_o <= core_div_i;
            tgt_bdiv_o <= bus_div_i;
        end
    end

endmodule

// File: rtl/clkrp_merge.sv
module clkrp_merge
    import clkrp_pkg::*;
#(
    parameter int CTRL_W = 16,
    parameter int SEL_W  = 8,
    parameter int SRC_W  = 3,
    parameter int CDIV_W = 4,
    parameter int BDIV_W = 2
) (
    input  clkrp_op_e         op_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [SRC_W-1:0]  tgt_src_i,
    input  logic [CDIV_W-1:0] tgt_cdiv_i,
    input  logic [BDIV_W-1:0] tgt_bdiv_i,
    output logic              addr_o,
    output logic [CTRL_W-1:0] data_o
);

    // Slot layout: divider at the slot base, source directly above it
    localparam int SLOT_SPAN = 2 * CDIV_W;
    localparam int LO_DIV    = 0;
    localparam int LO_SRC    = CDIV_W;
    localparam int HI_DIV    = SLOT_SPAN;
    localparam int HI_SRC    = SLOT_SPAN + CDIV_W;

    localparam logic [CTRL_W-1:0] SRC_ONES = CTRL_W'((1 << SRC_W) - 1);
    localparam logic [CTRL_W-1:0] DIV_ONES = CTRL_W'((1 << CDIV_W) - 1);
    localparam logic [SEL_W-1:0]  BUS_MASK = SEL_W'(((1 << BDIV_W) - 1) << BUS_LSB);
    localparam logic [SEL_W-1:0]  FLIP_BIT = SEL_W'(1 << SEL_BIT);

    logic              hi_live;
    logic [CTRL_W-1:0] src_ext, div_ext;
    logic [SEL_W-1:0]  sel_bus, sel_flip;

    assign hi_live  = (sel_i[SEL_BIT] == 1'b0);
    assign src_ext  = CTRL_W'(tgt_src_i);
    assign div_ext  = CTRL_W'(tgt_cdiv_i);
    assign sel_bus  = (sel_i & ~BUS_MASK) | (SEL_W'(tgt_bdiv_i) << BUS_LSB);
    assign sel_flip = sel_i ^ FLIP_BIT;

    always_comb begin
        addr_o = ADDR_CTRL;
        data_o = ctrl_i;
        unique case (op_i)
            OP_BUS: begin
                addr_o = ADDR_SEL;
                data_o = CTRL_W'(sel_bus);
            end
            OP_SRC: begin
                if (hi_live) begin
                    data_o = (ctrl_i & ~(SRC_ONES << LO_SRC)) | (src_ext << LO_SRC);
                end else begin
                    data_o = (ctrl_i & ~(SRC_ONES << HI_SRC)) | (src_ext << HI_SRC);
                end
            end
            OP_DIV: begin
                if (hi_live) begin
                    data_o = (ctrl_i & ~(DIV_ONES << LO_DIV)) | (div_ext << LO_DIV);
                end else begin
                    data_o = (ctrl_i & ~(DIV_ONES << HI_DIV)) | (div_ext << HI_DIV);
                end
            end
            OP_FLIP: begin
                addr_o = ADDR_SEL;
                data_o = CTRL_W'(sel_flip);
            end
            default: begin
                addr_o = ADDR_CTRL;
                data_o = ctrl_i;
            end
        endcase
    end

endmodule

// File: rtl/clkrp_top.sv
module clkrp_top #(
    parameter int              CTRL_W   = 16,
    parameter int              SEL_W    = 8,
    parameter int              SRC_W    = 3,
    parameter int              CDIV_W   = 4,
    parameter int              BDIV_W   = 2,
    parameter logic [CTRL_W-1:0] CTRL_RST = '0,
    parameter logic [SEL_W-1:0]  SEL_RST  = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [SRC_W-1:0]  src_sel_i,
    input  logic [CDIV_W-1:0] core_div_i,
    input  logic [BDIV_W-1:0] bus_div_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              wr_valid_o,
    output logic              wr_addr_o,
    output logic [CTRL_W-1:0] wr_data_o
);
    import clkrp_pkg::*;

    clkrp_op_e         op;
    logic              load;
    logic              up_req, down_req;
    logic [CTRL_W-1:0] ctrl_q;
    logic [SEL_W-1:0]  sel_q;
    logic [SRC_W-1:0]  tgt_src;
    logic [CDIV_W-1:0] tgt_cdiv;
    logic [BDIV_W-1:0] tgt_bdiv;
    logic [BDIV_W-1:0] cur_bdiv;

    assign cur_bdiv = sel_q[BUS_LSB +: BDIV_W];
    assign up_req   = (bus_div_i > cur_bdiv);
    assign down_req = (bus_div_i < cur_bdiv);

    clkrp_seq u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .up_req_i   (up_req),
        .down_req_i (down_req),
        .load_o     (load),
        .op_o       (op),
        .wr_valid_o (wr_valid_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    clkrp_image #(
        .CTRL_W   (CTRL_W),
        .SEL_W    (SEL_W),
        .SRC_W    (SRC_W),
        .CDIV_W   (CDIV_W),
        .BDIV_W   (BDIV_W),
        .CTRL_RST (CTRL_RST),
        .SEL_RST  (SEL_RST)
    ) u_image (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .src_sel_i  (src_sel_i),
        .core_div_i (core_div_i),
        .bus_div_i  (bus_div_i),
        .wr_valid_i (wr_valid_o),
        .wr_addr_i  (wr_addr_o),
        .wr_data_i  (wr_data_o),
        .ctrl_q_o   (ctrl_q),
        .sel_q_o    (sel_q),
        .tgt_src_o  (tgt_src),
        .tgt_cdiv_o (tgt_cdiv),
        .tgt_bdiv_o (tgt_bdiv)
    );

    clkrp_merge #(
        .CTRL_W (CTRL_W),
        .SEL_W  (SEL_W),
        .SRC_W  (SRC_W),
        .CDIV_W (CDIV_W),
        .BDIV_W (BDIV_W)
    ) u_merge (
        .op_i       (op),
        .ctrl_i     (ctrl_q),
        .sel_i      (sel_q),
        .tgt_src_i  (tgt_src),
        .tgt_cdiv_i (tgt_cdiv),
        .tgt_bdiv_i (tgt_bdiv),
        .addr_o     (wr_addr_o),
        .data_o     (wr_data_o)
    );

endmodule

// File: rtl/clkrp_checker.sv
module clkrp_checker #(
    parameter int              CTRL_W   = 16,
    parameter int              SEL_W    = 8,
    parameter int              CDIV_W   = 4,
    parameter logic [CTRL_W-1:0] CTRL_RST = '0,
    parameter logic [SEL_W-1:0]  SEL_RST  = '0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              wr_valid_o,
    input logic              wr_addr_o,
    input logic [CTRL_W-1:0] wr_data_o
);

    localparam int SLOT_SPAN = 2 * CDIV_W;

    logic [CTRL_W-1:0] ctrl_m;
    logic [SEL_W-1:0]  sel_m;

    // Independent mirror of both registers, built from the write stream
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_m <= CTRL_RST;
            sel_m  <= SEL_RST;
        end else if (wr_valid_o) begin
            if (wr_addr_o) sel_m  <= wr_data_o[SEL_W-1:0];
            else           ctrl_m <= wr_data_o;
        end
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !wr_valid_o); // R9

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(wr_valid_o)); // R9

    AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_SEL_ONE_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && wr_addr_o) |->
            ((wr_data_o[0] == sel_m[0]) || (wr_data_o[2:1] == sel_m[2:1]))); // R4

    AST_SEL_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && wr_addr_o) |->
            (wr_data_o[SEL_W-1:3] == sel_m[SEL_W-1:3] && wr_data_o[CTRL_W-1:SEL_W] == '0)); // R8

    AST_LO_SLOT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && !wr_addr_o && sel_m[0]) |->
            (wr_data_o[SLOT_SPAN-1:0] == ctrl_m[SLOT_SPAN-1:0])); // R10

    AST_HI_SLOT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && !wr_addr_o && !sel_m[0]) |->
            (wr_data_o[CTRL_W-1:SLOT_SPAN] == ctrl_m[CTRL_W-1:SLOT_SPAN])); // R10

endmodule

bind clkrp_top clkrp_checker #(
    .CTRL_W   (CTRL_W),
    .SEL_W    (SEL_W),
    .CDIV_W   (CDIV_W),
    .CTRL_RST (CTRL_RST),
    .SEL_RST  (SEL_RST)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
);

// File: tb/clkrp_top_tb.sv
`timescale 1ns/1ps
module clkrp_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  src = '0;
    logic [3:0]  cdiv = '0;
    logic [1:0]  bdiv = '0;
    logic        busy, done, wr_valid, wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Bench model of the two registers (reset values match the overrides below)
    logic [15:0] m_ctrl = 16'h7C96;
    logic [7:0]  m_sel  = 8'hE2;

    always #10 clk = ~clk;

    clkrp_top #(
        .CTRL_RST (16'h7C96),
        .SEL_RST  (8'hE2)
    ) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .src_sel_i  (src),
        .core_div_i (cdiv),
        .bus_div_i  (bdiv),
        .busy_o     (busy),
        .done_o     (done),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "busy after reset", 32'(busy), 32'd0);
        chk("R1", "done after reset", 32'(done), 32'd0);
        chk("R1", "wr_valid after reset", 32'(wr_valid), 32'd0);
    endtask

    // One clock change; poke >= 0 raises start with other targets mid-sequence
    task automatic run_switch(input logic [2:0] s, input logic [3:0] c,
                              input logic [1:0] b, input int poke, input string tag);
        logic        e_addr [6];
        logic [15:0] e_data [6];
        int          n;
        logic [7:0]  s8;
        logic [15:0] c16;
        logic [1:0]  ob;
        logic        lo_live;
        n   = 0;
        s8  = m_sel;
        c16 = m_ctrl;
        ob  = m_sel[2:1];
        lo_live = m_sel[0];
        // R5: rising bus divider first
        if (b > ob) begin
            s8[2:1] = b; e_addr[n] = 1'b1; e_data[n] = {8'h00, s8}; n++;
        end
        // R3: idle slot, source then divider
        if (!s8[0]) begin
            c16[6:4] = s;  e_addr[n] = 1'b0; e_data[n] = c16; n++;
            c16[3:0] = c;  e_addr[n] = 1'b0; e_data[n] = c16; n++;
        end else begin
            c16[14:12] = s; e_addr[n] = 1'b0; e_data[n] = c16; n++;
            c16[11:8]  = c; e_addr[n] = 1'b0; e_data[n] = c16; n++;
        end
        // R4: flip
        s8[0] = ~s8[0]; e_addr[n] = 1'b1; e_data[n] = {8'h00, s8}; n++;
        // R6: falling bus divider last
        if (b < ob) begin
            s8[2:1] = b; e_addr[n] = 1'b1; e_data[n] = {8'h00, s8}; n++;
        end

        @(negedge clk);
        src = s; cdiv = c; bdiv = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 10; cyc++) begin
            if (cyc == poke) begin
                start = 1'b1; src = ~s; cdiv = ~c; bdiv = ~b;
            end else begin
                start = 1'b0;
            end
            if (cyc < n) begin
                chk({"R9 ", tag}, $sformatf("wr_valid write %0d", cyc), 32'(wr_valid), 32'd1);
                chk({"R3 R4 ", tag}, $sformatf("wr_addr write %0d", cyc), 32'(wr_addr), 32'(e_addr[cyc]));
                chk({"R8 ", tag}, $sformatf("wr_data write %0d", cyc), 32'(wr_data), 32'(e_data[cyc]));
                if (wr_valid && !wr_addr) begin
                    if (lo_live) chk("R10", "live low slot", 32'(wr_data[7:0]), 32'(m_ctrl[7:0]));
                    else         chk("R10", "live high slot", 32'(wr_data[15:8]), 32'(m_ctrl[15:8]));
                end
            end else if (cyc == n) begin
                chk({"R9 ", tag}, "done after last write", 32'(done), 32'd1);
                chk({"R7 R9 ", tag}, "no extra write", 32'(wr_valid), 32'd0);
            end else begin
                chk({"R2 R9 ", tag}, "idle after done", 32'({busy, done, wr_valid}), 32'd0);
            end
            @(negedge clk);
        end
        start = 1'b0;
        m_ctrl = c16;
        m_sel  = s8;
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_switch(3'd5, 4'd9, 2'd3, -1, "R1 R5");
        run_switch(3'd2, 4'd4, 2'd0, -1, "R6");
        run_switch(3'd6, 4'd15, 2'd0, -1, "R7");
        run_switch(3'd1, 4'd3, 2'd2, 1, "R2");
        run_switch(3'd7, 4'd0, 2'd2, -1, "R7");
        run_switch(3'd0, 4'd1, 2'd1, -1, "R6");
        run_switch(3'd4, 4'd6, 2'd3, 2, "R2 R5");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule